// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block watches a small set of external interrupt pins and turns a qualifying edge on each into a latched request. Each channel has its own active-edge selection, an enable bit and a request flag. While the system clock runs, a pin is first brought into the clock domain and then passed through a digital noise filter. A change of level is believed only after it has been seen on consecutive samples, so a pulse that lasts a single clock is thrown away. The clock here is the already-divided internal clock.

In stop or wait mode the clock is halted and the filter cannot work. Each channel therefore also has a capture flop that the pin edge itself clocks. It records an active edge with no clock at all, and an enabled capture drives the wake output at once. When the clock restarts, the captured edge is carried through a synchronizer into the request flag and the capture flop is cleared. Software sets the edge polarity and the enables, clears flags and reads the filtered pin levels through a small register port.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset the polarity, enable and request registers read 0, and `irq` and `wake` are 0.
- R2: In run mode an active-level pulse of FILT_LEN (2) or more clock periods sets the channel's request bit. A pulse of one clock period leaves it at 0.
- R3: Polarity bit value 0 selects the rising edge and 1 selects the falling edge (register select 0). A step in the non-selected direction does not set the request.
- R4: A pin change that is stable before rising clock edge k sets the request bit at edge k+4, and not at edge k+3. The filtered level changes at edge k+3.
- R5: A write to the request register (select 2) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: When a request clear and a detected edge fall on the same clock edge, the request bit ends at 1.
- R7: `irq[i]` is high exactly when request bit i and enable bit i (select 1) are both 1. In run mode `wake` is the OR of `irq`. Clearing a request before enabling the channel produces no interrupt.
- R8: Edge detection acts on the filtered level combined with the polarity. Switching a channel from rising to falling while its pin is low sets its request bit on the next clock edge.
- R9: Select 3 reads the filtered pin levels. Writes to select 3 change no register.
- R10: With `lp_mode` high and the clock stopped, an active edge on an enabled channel raises `wake` with no clock edge. An edge on a disabled channel does not raise it.
- R11: After `lp_mode` falls and the clock runs, an edge captured in low-power mode sets the request bit within 8 clocks. Once that bit is cleared it stays 0 with no new edge.
- R12: Channels are independent. With one pin signal driving both channels, one set to rising and the other to falling, a rising step sets only the rising channel and a falling step sets only the falling channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; may be stopped while `lp_mode` is high |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| lp_mode | input | 1 | High while in stop or wait mode |
| pin | input | NUM_CH | Raw external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 polarity, 1 enable, 2 request, 3 level (read-only) |
| wr_data | input | NUM_CH | Write data, one bit per channel |
| rd_addr | input | 2 | Read select, same encoding as `wr_addr` |
| rd_data | output | NUM_CH | Read data for `rd_addr` |
| irq | output | NUM_CH | Per-channel interrupt, request AND enable |
| wake | output | 1 | Low-power release request |

## Verification
The two functions that can fall in the same clock edge are the software clear of a request and the setting of that same request by a filtered edge. The bench changes a pin and counts off the four clock edges of synchronizer and filter latency. It then issues the clear write so that it is sampled on exactly the edge where the edge detector fires. The case is judged by reading the request register afterwards: it must hold 1. A following plain clear must then bring it to 0.

// File: rtl/ext_irq_pkg.sv
// Package: shared register-select encoding for the external interrupt unit.
// Assumes: a two-bit register select on both write and read ports.
package ext_irq_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_POL = 2'd0,   // edge polarity, 1 = falling
        SEL_EN  = 2'd1,   // channel enables
        SEL_REQ = 2'd2,   // request flags, write 0 clears
        SEL_LVL = 2'd3    // filtered pin levels, read-only
    } reg_sel_e;

endpackage

// File: rtl/ext_irq_sync.sv
// Module: multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; resets to 0 synchronously.
module ext_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d};
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_filter.sv
// Module: digital noise filter on a synchronized bit.
// The output takes a new value only after LEN consecutive samples agree on it.
// Assumes: LEN >= 2; input already synchronized to clk.
module ext_irq_filter #(
    parameter int unsigned LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic lvl
);

    localparam int unsigned HW = LEN - 1;

    logic [HW-1:0] hist_q;
    logic          lvl_q;
    logic          agree;

    // All LEN samples (history plus current) hold the same value.
    assign agree = (&{hist_q, smp}) | ~(|{hist_q, smp});

    // Keep a short history of samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q[0] <= smp;
            for (int k = 1; k < int'(HW); k++) begin
                hist_q[k] <= hist_q[k-1];
            end
        end
    end

    // Accept a new level only when the whole window agrees on it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (agree && (smp != lvl_q)) begin
            lvl_q <= smp;
        end
    end

    assign lvl = lvl_q;

    // R2: a new filtered level was present on the last two samples
    p_lvl_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> (($past(smp) == lvl) && ($past(hist_q[0]) == lvl)));

endmodule

// File: rtl/ext_irq_chan.sv
// Module: one interrupt channel.
// Run path: synchronizer, filter, edge detect. Low-power path: an edge-clocked
// capture flop, carried into the request flag once the clock restarts.
// Assumes: pol and lp_mode are quasi-static; the capture flop's clear is
// asynchronous because no clock exists while it is armed.
module ext_irq_chan #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic lp_mode,
    input  logic clr,
    output logic req,
    output logic lvl,
    output logic cap
);

    logic pin_s;
    logic act, act_d;
    logic run_hit;
    logic act_pin;
    logic cap_q, cap_s, ack_q, cap_clr_n;
    logic cap_hit;
    logic set_ev;
    logic req_q;

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
    );

    ext_irq_filter #(.LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .smp(pin_s), .lvl(lvl)
    );

    // Active-high view of the filtered level; polarity folds in here.
    assign act = lvl ^ pol;

    // Remember the previous active view for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= 1'b0;
        else        act_d <= act;
    end

    assign run_hit = act & ~act_d;

    // Raw pin turned so that the selected edge is always a rising edge.
    assign act_pin   = pin ^ pol;
    assign cap_clr_n = rst_n & ~ack_q;

    // Capture an active edge with no clock while in low-power mode.
    always_ff @(posedge act_pin or negedge cap_clr_n) begin
        if (!cap_clr_n) cap_q <= 1'b0;
        else            cap_q <= lp_mode;
    end

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_q), .q(cap_s)
    );

    // Acknowledge a synchronized capture and hold the capture flop cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)               ack_q <= 1'b0;
        else if (cap_s && !ack_q) ack_q <= 1'b1;
        else if (!cap_s)          ack_q <= 1'b0;
    end

    assign cap_hit = cap_s & ~ack_q;
    assign set_ev  = run_hit | cap_hit;

    // Request flag: a detected edge wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b0;
        else if (set_ev) req_q <= 1'b1;
        else if (clr)    req_q <= 1'b0;
    end

    assign req = req_q;
    assign cap = cap_q;

    // R6: a detection always leaves the flag set, clear or no clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_ev) |-> req_q);

    // R5: a clear with no detection empties the flag
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr && !set_ev) |-> !req_q);

    // R5: the flag only drops after a software clear
    p_fall_needs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(clr));

    // R11: an acknowledged capture has been moved into the flag
    p_capture_moved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> req_q);

endmodule

// File: rtl/ext_irq_edge_unit.sv
// Module: top of the filtered external interrupt edge detector.
// Holds polarity and enable registers, decodes the register port, and
// combines channel requests into interrupt and wake outputs.
// Assumes: register writes occur only while the clock runs.
module ext_irq_edge_unit
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_mode,
    input  logic [NUM_CH-1:0] pin,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [NUM_CH-1:0] rd_data,
    output logic [NUM_CH-1:0] irq,
    output logic              wake
);

    logic [NUM_CH-1:0] pol_q, en_q;
    logic [NUM_CH-1:0] req, lvl, cap;
    logic [NUM_CH-1:0] clr_vec;

    // Polarity and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == SEL_POL) pol_q <= wr_data;
            if (wr_addr == SEL_EN)  en_q  <= wr_data;
        end
    end

    // Request clear strobes: a written 0 clears that channel.
    assign clr_vec = (wr_en && (wr_addr == SEL_REQ)) ? ~wr_data : '0;

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
        ext_irq_chan #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin[i]),
            .pol    (pol_q[i]),
            .lp_mode(lp_mode),
            .clr    (clr_vec[i]),
            .req    (req[i]),
            .lvl    (lvl[i]),
            .cap    (cap[i])
        );
    end

    // Read multiplexer over the four registers.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_POL: rd_data = pol_q;
            SEL_EN:  rd_data = en_q;
            SEL_REQ: rd_data = req;
            SEL_LVL: rd_data = lvl;
            default: rd_data = '0;
        endcase
    end

    assign irq  = req & en_q;
    assign wake = (|irq) | (lp_mode & (|(cap & en_q)));

    // R3: a polarity write lands in the register
    p_pol_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == SEL_POL)) |-> (pol_q == $past(wr_data)));

    // R9: a write to the level select leaves all registers alone
    p_lvl_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == SEL_LVL)) |-> ($stable(pol_q) && $stable(en_q)));

    // R7: in run mode, wake means some interrupt is pending
    p_wake_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && wake) |-> (|irq));

endmodule

// File: tb/ext_irq_edge_unit_bench.sv
module ext_irq_edge_unit_bench;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       lp_mode = 1'b0;
    logic [1:0] pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [1:0] wr_data = 2'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [1:0] rd_data;
    logic [1:0] irq;
    logic       wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ext_irq_edge_unit u_ext_irq_edge_unit (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .pin(pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    // 50 MHz clock that can be halted low for low-power mode.
    initial begin
        forever begin
            #10;
            if (clk_run) clk = ~clk;
            else         clk = 1'b0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Set polarity and idle pins, let everything settle, clear all flags.
    task automatic prep(input logic [1:0] p, input logic [1:0] idle);
        wr(2'd0, p);
        pin = idle;
        tick(8);
        wr(2'd2, 2'b00);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [1:0] v;
        tick(5);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(2'd0, v); chk("R1 pol", v, 2'b00);
        rd(2'd1, v); chk("R1 en", v, 2'b00);
        rd(2'd2, v); chk("R1 req", v, 2'b00);
        chk("R1 irq", irq, 2'b00);
        chk("R1 wake", {1'b0, wake}, 2'b00);

        // R2 R3 R12: pulse width sweep, both channels, both polarities
        for (int ch = 0; ch < 2; ch++) begin
            for (int p = 0; p < 2; p++) begin
                for (int w = 1; w <= 4; w++) begin
                    logic [1:0] idle;
                    logic [1:0] exp;
                    idle = p[0] ? 2'b11 : 2'b00;
                    prep(idle, idle);
                    pin[ch] = ~idle[ch];
                    tick(w);
                    pin[ch] = idle[ch];
                    tick(8);
                    exp = 2'b00;
                    if (w >= 2) exp[ch] = 1'b1;
                    rd(2'd2, v);
                    chk($sformatf("R2 R12 ch%0d pol%0d width%0d", ch, p, w), v, exp);
                end
                // R3: a lone step in the wrong direction sets nothing
                begin
                    logic [1:0] base;
                    base = p[0] ? 2'b00 : 2'b11;
                    prep(p[0] ? 2'b11 : 2'b00, base);
                    pin[ch] = ~base[ch];
                    tick(8);
                    rd(2'd2, v);
                    chk($sformatf("R3 ch%0d pol%0d opposite step", ch, p), v, 2'b00);
                end
            end
        end

        // R4: latency of pin change to level and request
        prep(2'b00, 2'b00);
        pin[0] = 1'b1;
        tick(4);
        rd(2'd2, v); chk("R4 req not yet", v, 2'b00);
        rd(2'd3, v); chk("R4 R9 level", v, 2'b01);
        tick(1);
        rd(2'd2, v); chk("R4 req set", v, 2'b01);

        // R9: writes to the level select are ignored
        wr(2'd1, 2'b10);
        wr(2'd3, 2'b11);
        rd(2'd0, v); chk("R9 pol kept", v, 2'b00);
        rd(2'd1, v); chk("R9 en kept", v, 2'b10);
        rd(2'd2, v); chk("R9 req kept", v, 2'b01);
        wr(2'd1, 2'b00);

        // R5: write 1 keeps, write 0 clears
        wr(2'd2, 2'b11);
        rd(2'd2, v); chk("R5 write one keeps", v, 2'b01);
        wr(2'd2, 2'b10);
        rd(2'd2, v); chk("R5 write zero clears", v, 2'b00);

        // R6: clear and detection on the same edge
        prep(2'b00, 2'b00);
        pin[0] = 1'b1;
        tick(4);
        wr(2'd2, 2'b00);
        rd(2'd2, v); chk("R6 set wins", v, 2'b01);
        wr(2'd2, 2'b00);
        rd(2'd2, v); chk("R6 later clear", v, 2'b00);

        // R7: interrupt gating by enable, clear before enable
        prep(2'b00, 2'b00);
        pin[1] = 1'b1; tick(3); pin[1] = 1'b0; tick(8);
        chk("R7 irq disabled", irq, 2'b00);
        chk("R7 wake disabled", {1'b0, wake}, 2'b00);
        wr(2'd1, 2'b10);
        chk("R7 irq enabled", irq, 2'b10);
        chk("R7 wake enabled", {1'b0, wake}, 2'b01);
        wr(2'd1, 2'b00);
        wr(2'd2, 2'b00);
        wr(2'd1, 2'b10);
        chk("R7 clear then enable", irq, 2'b00);
        chk("R7 wake after clear", {1'b0, wake}, 2'b00);
        wr(2'd1, 2'b00);

        // R8: polarity switch with pin low makes a false request
        prep(2'b00, 2'b00);
        wr(2'd0, 2'b01);
        tick(2);
        rd(2'd2, v); chk("R8 false edge", v, 2'b01);

        // R12: one signal on both pins, ch0 rising, ch1 falling
        prep(2'b10, 2'b00);
        pin = 2'b11; tick(8);
        rd(2'd2, v); chk("R12 rising only ch0", v, 2'b01);
        wr(2'd2, 2'b00);
        pin = 2'b00; tick(8);
        rd(2'd2, v); chk("R12 falling only ch1", v, 2'b10);

        // R10 R11: low-power capture and transfer
        prep(2'b00, 2'b00);
        wr(2'd1, 2'b01);
        lp_mode = 1'b1;
        clk_run = 1'b0;
        #40;
        chk("R10 idle wake", {1'b0, wake}, 2'b00);
        pin[1] = 1'b1; #10;
        chk("R10 disabled no wake", {1'b0, wake}, 2'b00);
        pin[0] = 1'b1; #10;
        chk("R10 enabled wake", {1'b0, wake}, 2'b01);
        #20;
        lp_mode = 1'b0;
        clk_run = 1'b1;
        tick(8);
        rd(2'd2, v); chk("R11 transferred", v, 2'b11);
        chk("R11 irq", irq, 2'b01);
        wr(2'd2, 2'b00);
        rd(2'd2, v); chk("R11 cleared", v, 2'b00);
        chk("R11 wake low", {1'b0, wake}, 2'b00);
        tick(6);
        rd(2'd2, v); chk("R11 no repeat", v, 2'b00);

        finish_run();
    end

endmodule